// File: doc/BRIEF.md
# Fractional Reference Clock Divider

The block derives a reference clock from one of several slow input clocks. Each half-period of the output spans N + M/512 rising edges of the selected input on average. The output frequency is therefore the input frequency divided by 2·(N + M/512). N is a 15-bit integer part and M is a 9-bit trim. A 9-bit phase accumulator adds M at every half-period boundary. A carry out of that accumulator lengthens the following half-period by one input cycle.

Everything runs in one system clock domain. The input clocks arrive as levels. Each one passes through a two-stage synchronizer, and its rising edges are counted. Software writes N and M into staging fields. Those values do nothing until software sets a switch request bit. Hardware clears that bit again when it loads the staged pair into the running divider. A run bit starts the generator and an output-enable bit gates the pin. A read-only busy flag reports a running or still-high generator, and the source select can only be changed while that flag is clear.

Top module: `refclk_div`

## Requirements
- R1: After reset every register field reads 0 and `ref_out` is low.
- R2: With running N = 0 and M = 0 the output follows the selected input, so its period equals the input period.
- R3: With M = 0 and N > 0 each output period spans exactly 2N rising edges of the selected input.
- R4: With M > 0 each half-period lasts N or N + 1 input edges. A 9-bit accumulator adds M at every half-period boundary, and a carry selects N + 1 for the next half-period. Any 512/gcd run of half-periods therefore averages N + M/512.
- R5: With N = 0 and M > 0 the divider behaves as if N were 1.
- R6: Writing new N (bits 30:16 of the control word at byte offset 0x00) or M (bits 31:23 of the trim word at offset 0x10) without a switch request leaves the output unchanged. The staged value reads back.
- R7: Writing 1 to control bit 9 requests a divider switch. The bit reads 1 for one cycle and then clears, and from then on the output uses the staged N and M. Writing 0 to bit 9 has no effect.
- R8: Control bit 8 is read-only and reads 1 while the run bit (bit 15) is set or the generator output is high. It reads 0 otherwise.
- R9: A write to the source select (control bits 3:0) takes effect only if bit 8 is 0 at the time of the write. Otherwise the select keeps its value.
- R10: While the output-enable bit (bit 12) is 0, `ref_out` stays low.
- R11: After the run bit is cleared, the generator finishes its current high phase and then stays low.
- R12: Register reads return data one cycle after `rd_addr` is presented. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_clk | input | NUM_SRC | Selectable input clock levels (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Registered read data |
| ref_out | output | 1 | Divided reference clock, registered |

## Verification
A selected input edge reaches the divider three system cycles after the level changes: two synchronizer stages and one select register. The output register adds one more cycle. That latency is the same at every output edge, so the bench measures output periods between rising edges of `ref_out` and discards the first period after any reconfiguration. For the fractional settings the bench measures a whole number of accumulator cycles, in which the number of carries is fixed whatever the starting phase. Read data arrives one cycle after the address, so the bench samples it on the falling edge after the capturing rising edge. The bench polls the busy flag instead of assuming a fixed delay for the generator to drain.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  // Register byte offsets (software decodes these)
  localparam int CTRL_OFS = 'h00;
  localparam int TRIM_OFS = 'h10;
  // Control word bit positions
  localparam int SEL_LSB  = 0;
  localparam int BUSY_BIT = 8;
  localparam int SWAP_BIT = 9;
  localparam int OE_BIT   = 12;
  localparam int RUN_BIT  = 15;
  localparam int N_LSB    = 16;
  // Trim word bit position
  localparam int M_LSB    = 23;
  // Default field widths
  localparam int DEF_N_W  = 15;
  localparam int DEF_M_W  = 9;

  typedef struct packed {
    logic [DEF_N_W-1:0] n;
    logic [DEF_M_W-1:0] m;
  } div_cfg_t;
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 4,
  parameter int N_W    = DEF_N_W,
  parameter int M_W    = DEF_M_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              load_ack,
  output logic [31:0]       rd_data,
  output logic [SEL_W-1:0]  sel_q,
  output logic              run_q,
  output logic              oe_q,
  output logic              swap_q,
  output logic [N_W-1:0]    stg_n,
  output logic [M_W-1:0]    stg_m
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_TRIM = ADDR_W'(TRIM_OFS);

  logic wr_ctrl, wr_trim;
  logic [31:0] rd_v;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_trim = wr_en && (wr_addr == A_TRIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      run_q  <= 1'b0;
      oe_q   <= 1'b0;
      swap_q <= 1'b0;
      stg_n  <= '0;
      stg_m  <= '0;
    end else begin
      swap_q <= (swap_q & ~load_ack) | (wr_ctrl & wr_data[SWAP_BIT]);
      if (wr_ctrl) begin
        run_q <= wr_data[RUN_BIT];
        oe_q  <= wr_data[OE_BIT];
        stg_n <= wr_data[N_LSB +: N_W];
        if (!busy) sel_q <= wr_data[SEL_LSB +: SEL_W];
      end
      if (wr_trim) stg_m <= wr_data[M_LSB +: M_W];
    end
  end

  always_comb begin
    rd_v = '0;
    if (rd_addr == A_CTRL) begin
      rd_v[SEL_LSB +: SEL_W] = sel_q;
      rd_v[BUSY_BIT]         = busy;
      rd_v[SWAP_BIT]         = swap_q;
      rd_v[OE_BIT]           = oe_q;
      rd_v[RUN_BIT]          = run_q;
      rd_v[N_LSB +: N_W]     = stg_n;
    end else if (rd_addr == A_TRIM) begin
      rd_v[M_LSB +: M_W]     = stg_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_v;
  end
endmodule

// File: rtl/refclk_src_sync.sv
module refclk_src_sync #(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0]   sel,
  output logic               lvl,
  output logic               rise
);
  logic [NUM_SRC-1:0] meta_q, sync_q;
  logic lvl_q, prev_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= src_clk[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= sync_q[sel];
      prev_q <= lvl_q;
    end
  end

  assign lvl  = lvl_q;
  assign rise = lvl_q & ~prev_q;
endmodule

// File: rtl/refclk_frac_core.sv
module refclk_frac_core #(
  parameter int N_W = 15,
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           swap,
  input  logic [N_W-1:0] stg_n,
  input  logic [M_W-1:0] stg_m,
  input  logic           lvl,
  input  logic           rise,
  output logic           gen_q,
  output logic           load_ack
);
  localparam int CW = N_W + 1;

  logic [N_W-1:0] run_n;
  logic [M_W-1:0] run_m, acc_q, acc_sum;
  logic [CW-1:0]  cnt_q, half_q;
  logic           carry, bypass;

  function automatic logic [CW-1:0] eff_n(input logic [N_W-1:0] n,
                                          input logic [M_W-1:0] m);
    if (n == '0 && m != '0) eff_n = CW'(1);
    else                    eff_n = {1'b0, n};
  endfunction

  assign bypass           = (run_n == '0) && (run_m == '0);
  assign {carry, acc_sum} = {1'b0, acc_q} + {1'b0, run_m};
  assign load_ack         = swap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_n <= '0;
      run_m <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      half_q <= '0;
      gen_q <= 1'b0;
    end else if (swap) begin
      run_n  <= stg_n;
      run_m  <= stg_m;
      acc_q  <= '0;
      cnt_q  <= '0;
      half_q <= eff_n(stg_n, stg_m);
    end else if (bypass) begin
      gen_q <= run ? lvl : (gen_q & lvl);
    end else if (run || gen_q) begin
      if (rise) begin
        if (cnt_q + 1'b1 >= half_q) begin
          gen_q  <= ~gen_q;
          cnt_q  <= '0;
          acc_q  <= acc_sum;
          half_q <= eff_n(run_n, run_m) + CW'(carry);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else begin
      cnt_q  <= '0;
      acc_q  <= '0;
      half_q <= eff_n(run_n, run_m);
    end
  end
endmodule

// File: rtl/refclk_div.sv
module refclk_div
  import refclk_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 5,
  parameter int N_W     = DEF_N_W,
  parameter int M_W     = DEF_M_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic               ref_out
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [SEL_W-1:0] sel_q;
  logic             run_q, oe_q, swap_q, gen_q, load_ack, busy;
  logic [N_W-1:0]   stg_n;
  logic [M_W-1:0]   stg_m;
  logic             lvl, rise;

  assign busy = run_q | gen_q;

  refclk_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .N_W(N_W), .M_W(M_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .busy(busy), .load_ack(load_ack), .rd_data(rd_data),
    .sel_q(sel_q), .run_q(run_q), .oe_q(oe_q), .swap_q(swap_q),
    .stg_n(stg_n), .stg_m(stg_m)
  );

  refclk_src_sync #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) sync_i (
    .clk(clk), .rst(rst), .src_clk(src_clk), .sel(sel_q),
    .lvl(lvl), .rise(rise)
  );

  refclk_frac_core #(.N_W(N_W), .M_W(M_W)) core_i (
    .clk(clk), .rst(rst), .run(run_q), .swap(swap_q), .stg_n(stg_n),
    .stg_m(stg_m), .lvl(lvl), .rise(rise), .gen_q(gen_q), .load_ack(load_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) ref_out <= 1'b0;
    else     ref_out <= gen_q & oe_q;
  end
endmodule

// File: rtl/refclk_div_chk.sv
module refclk_div_chk
  import refclk_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_out,
  input logic              busy,
  input logic              run_q,
  input logic              oe_q,
  input logic              swap_q,
  input logic [SEL_W-1:0]  sel_q,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data
);
  logic swap_set;
  assign swap_set = wr_en && (wr_addr == ADDR_W'(CTRL_OFS)) && wr_data[SWAP_BIT];

  p_reset_state_r1: assert property (@(posedge clk) rst |=> (!ref_out && !run_q && !swap_q));
  p_swap_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (swap_q && !swap_set) |=> !swap_q);
  p_sel_locked_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(sel_q));
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !oe_q |=> !ref_out);
  p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !ref_out);
endmodule

bind refclk_div refclk_div_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .ref_out(ref_out), .busy(busy), .run_q(run_q),
  .oe_q(oe_q), .swap_q(swap_q), .sel_q(sel_q), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/refclk_div_tb_top.sv
module refclk_div_tb_top;
  localparam int NSRC = 16;
  localparam int AW   = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_clk = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic [31:0]     rd_data;
  logic            ref_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int src_cnt [NSRC];

  always #10 clk = ~clk;

  // source i toggles every i+2 cycles: period 2*(i+2) system cycles
  initial for (int i = 0; i < NSRC; i++) src_cnt[i] = 0;
  always @(negedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (src_cnt[i] == i + 1) begin
        src_cnt[i] = 0;
        src_clk[i] = ~src_clk[i];
      end else src_cnt[i] = src_cnt[i] + 1;
    end
  end

  refclk_div dut_i (
    .clk(clk), .rst(rst), .src_clk(src_clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ref_out(ref_out)
  );

  function automatic logic [31:0] ctrl_w(int sel, int n, bit run, bit oe, bit swap);
    ctrl_w = '0;
    ctrl_w[3:0]   = 4'(sel);
    ctrl_w[30:16] = 15'(n);
    ctrl_w[15]    = run;
    ctrl_w[12]    = oe;
    ctrl_w[9]     = swap;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(int addr, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(int addr, output logic [31:0] d);
    @(negedge clk);
    rd_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  // cycles spanned by k output periods, measured rise to rise
  task automatic span(int k, output int cyc);
    logic p;
    int g, r;
    p = ref_out; g = 0;
    while (g < 5000) begin
      @(negedge clk); g++;
      if (ref_out && !p) break;
      p = ref_out;
    end
    p = ref_out; cyc = 0; r = 0;
    while (r < k && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (ref_out && !p) r++;
      p = ref_out;
    end
  endtask

  task automatic settled_span(int k, output int cyc);
    int dummy;
    span(1, dummy);
    span(k, cyc);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1", "ref_out after reset", ref_out, 0);
    reg_rd('h00, d); check("R1", "control after reset", d, 0);
    reg_rd('h10, d); check("R1", "trim after reset", d, 0);
  endtask

  task automatic t_integer;
    logic [31:0] d; int c;
    reg_wr('h00, ctrl_w(0, 3, 1, 1, 1));
    settled_span(1, c); check("R3", "N=3 period on 4-cycle input", c, 24);
    reg_rd('h00, d);
    check("R12", "control readback with busy", d, 32'h0003_9100);
    check("R8", "busy bit while running", d[8], 1);
    check("R7", "swap bit self-cleared", d[9], 0);
  endtask

  task automatic t_staged;
    logic [31:0] d; int c;
    reg_wr('h00, ctrl_w(0, 5, 1, 1, 0));
    settled_span(1, c); check("R6", "period unchanged by staged N", c, 24);
    reg_rd('h00, d); check("R6", "staged N readback", d[30:16], 5);
    reg_wr('h10, 32'd200 << 23);
    settled_span(1, c); check("R6", "period unchanged by staged M", c, 24);
    reg_wr('h10, 32'h0);
    reg_wr('h00, ctrl_w(0, 5, 1, 1, 1));
    settled_span(1, c); check("R7", "period after switch N=5", c, 40);
  endtask

  task automatic t_sel_locked;
    logic [31:0] d;
    reg_wr('h00, ctrl_w(1, 5, 1, 1, 0));
    reg_rd('h00, d); check("R9", "select held while busy", d[3:0], 0);
  endtask

  task automatic t_oe_off;
    logic [31:0] d; int hi;
    reg_wr('h00, ctrl_w(0, 5, 1, 0, 0));
    @(negedge clk);
    hi = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); if (ref_out) hi++; end
    check("R10", "high samples with output disabled", hi, 0);
    reg_rd('h00, d); check("R8", "busy with output disabled", d[8], 1);
  endtask

  task automatic t_stop;
    logic [31:0] d; int w, hi;
    reg_wr('h00, ctrl_w(0, 5, 1, 1, 0));
    repeat (30) @(negedge clk);
    reg_wr('h00, ctrl_w(0, 5, 0, 1, 0));
    w = 0;
    do begin reg_rd('h00, d); w++; end while (d[8] && w < 200);
    check("R11", "generator drained to idle", d[8], 0);
    hi = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (ref_out) hi++; end
    check("R11", "output low after stop", hi, 0);
  endtask

  task automatic t_bypass;
    logic [31:0] d; int c;
    reg_wr('h00, ctrl_w(1, 0, 0, 1, 1));
    reg_rd('h00, d); check("R9", "select accepted when idle", d[3:0], 1);
    reg_wr('h00, ctrl_w(1, 0, 1, 1, 0));
    settled_span(4, c); check("R2", "bypass four periods of 6-cycle input", c, 24);
  endtask

  task automatic t_frac;
    logic [31:0] d; int c;
    reg_wr('h10, 32'd256 << 23);
    reg_wr('h00, ctrl_w(1, 1, 1, 1, 1));
    settled_span(8, c); check("R4", "N=1 M=256 eight periods", c, 144);
    reg_wr('h10, 32'd128 << 23);
    reg_wr('h00, ctrl_w(1, 2, 1, 1, 1));
    settled_span(4, c); check("R4", "N=2 M=128 four periods", c, 108);
    settled_span(1, c);
    check("R4", "single period within bounds", (c >= 24 && c <= 36) ? 1 : 0, 1);
    reg_wr('h10, 32'd256 << 23);
    reg_wr('h00, ctrl_w(1, 0, 1, 1, 1));
    settled_span(8, c); check("R5", "N=0 M=256 acts as N=1", c, 144);
    reg_wr('h10, 32'd511 << 23);
    reg_rd('h10, d); check("R12", "max trim placement", d, 32'hFF80_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_integer();
    t_staged();
    t_sel_locked();
    t_oe_off();
    t_stop();
    t_bypass();
    t_frac();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule